// File: doc/BRIEF.md
# Banked Host Register Port

This block is the microprocessor-facing register port of a larger controller. A host reaches it through a 16-bit data bus, a chip select, two strobe pins and a 5-bit word address. Each word address is the byte address divided by two. Two static mode pins pick the bus style and the address source:

- With the style pin low, the strobes are separate active-low read and write strobes.
- With the style pin high, one pin is a read/not-write level and the other is an active-low data strobe.
- With the multiplex pin low, the address comes from the dedicated address pins.
- With the multiplex pin high, the address travels on data bits 5..1 and is held by an address-latch-enable pulse.

All inputs are sampled on the system clock.

The word space is split into three banks. A common window (words 0..7 and word 31) is reachable whatever bank is current. Word 31 holds the bank number. At several words the host writes a setting register but reads a separate display register. The display side is loaded by the protocol engines through a narrow load port. The block decodes the address, keeps the bank number, routes writes into setting storage, and returns read data with a fixed latency.

Top module: `hreg_port`

## Requirements
- R1: After synchronous reset the bank number is 0, `data_oe_o` is low and `data_o` is 0000h.
- R2: With `style_68_i`=0, a low `rd_rw_i` together with a low `cs_n_i` is a read and a low `wr_ds_i` together with a low `cs_n_i` is a write. Strobes with `cs_n_i` high have no effect. `data_o` is 0000h whenever `data_oe_o` is low.
- R3: With `style_68_i`=1, a low `wr_ds_i` together with a low `cs_n_i` is a read when `rd_rw_i`=1 and a write when `rd_rw_i`=0.
- R4: With `addr_mux_i`=1, the word address is `data_i[5:1]`, taken from the last clock sample while `ale_i` was high, and `a_i` is ignored.
- R5: Words 0..7 and 31 reach the same storage in every bank.
- R6: Writing 0000h, 0001h or 0002h to word 31 selects bank 0, 1 or 2. Reading word 31 returns the bank number in bits [1:0], with all other bits 0.
- R7: A write of any value above 0002h to word 31 leaves the bank unchanged.
- R8: At split words the host write goes to the setting register, and the read returns the display value last loaded through the engine port. Split words are 3 and 5 (common), bank 0 words 8, 9, 11..18, 24 and 25, and bank 1 words 8..15.
- R9: Reserved words and write-only words read 0000h. Writes to reserved words and to read-only words change nothing that can be read. Read-only words are 1 and 4 (common) and bank 0 words 20..23, 28 and 29. The only write-only word is bank 0 word 10.
- R10: Read/write words hold separate contents per bank. These are common words 0 and 2, bank 1 words 16..23, and bank 2 words 8..19.
- R11: A write stores the data sampled in the last clock while the strobe was active, committed once the strobe ends. `data_oe_o` rises at the third rising clock edge after the read strobe is first driven, and falls at the third edge after it is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| style_68_i | input | 1 | Bus style: 0 separate read/write strobes, 1 read-write level plus data strobe |
| addr_mux_i | input | 1 | 0 address on `a_i`, 1 address on data bits 5..1 |
| cs_n_i | input | 1 | Active-low chip select |
| a_i | input | 5 | Word address (non-multiplexed) |
| ale_i | input | 1 | Address latch enable (multiplexed) |
| rd_rw_i | input | 1 | Read strobe (style 0) or read/not-write level (style 1) |
| wr_ds_i | input | 1 | Write strobe (style 0) or data strobe (style 1) |
| data_i | input | 16 | Host write data and multiplexed address |
| data_o | output | 16 | Host read data |
| data_oe_o | output | 1 | Read data valid / bus drive enable |
| eng_we_i | input | 1 | Engine display-register load strobe |
| eng_bank_i | input | 2 | Engine load bank (ignored for common words) |
| eng_word_i | input | 5 | Engine load word |
| eng_data_i | input | 16 | Engine load data |

## Verification
The bench targets four hazards:

- **Split words.** It writes a split word and then reads back the display value. A decoder that shares one register per address would return the host's own write.
- **Bank select limits.** It writes out-of-range values to the bank select word. A design that truncates the value to two bits would jump to bank 3 or bank 1.
- **Multiplexed address.** It moves the address during the latch-enable pulse, and puts noise on the address pins. A design that latches on the wrong sample, or reads the address pins, would hit the wrong word.
- **Strobe timing.** It changes data while a write strobe is held, and times the read-enable edges against the clock. This exposes writes committed on strobe entry and any extra or missing pipeline stage.

// File: rtl/hreg_pkg.sv
package hreg_pkg;

  typedef enum logic [2:0] {
    LK_RES, LK_SHARED, LK_SPLIT, LK_RO, LK_WO, LK_BSEL
  } loc_kind_e;

  function automatic logic is_common(input int w, input int bsel, input int clast);
    return (w <= clast) || (w == bsel);
  endfunction

  // Location class for a (bank, word) pair.
  function automatic loc_kind_e loc_kind(input int b, input int w,
                                         input int bsel, input int clast);
    if (w == bsel) return LK_BSEL;
    if (w <= clast) begin
      case (w)
        0, 2:    return LK_SHARED;
        1, 4:    return LK_RO;
        3, 5:    return LK_SPLIT;
        default: return LK_RES;
      endcase
    end
    case (b)
      0: begin
        if (w == 10) return LK_WO;
        if (w == 8 || w == 9 || (w >= 11 && w <= 18) || w == 24 || w == 25)
          return LK_SPLIT;
        if ((w >= 20 && w <= 23) || w == 28 || w == 29) return LK_RO;
        return LK_RES;
      end
      1: begin
        if (w >= 8 && w <= 15)  return LK_SPLIT;
        if (w >= 16 && w <= 23) return LK_SHARED;
        return LK_RES;
      end
      2: begin
        if (w >= 8 && w <= 19) return LK_SHARED;
        return LK_RES;
      end
      default: return LK_RES;
    endcase
  endfunction

endpackage

// File: rtl/hreg_bus_front.sv
module hreg_bus_front #(
  parameter int AW = 5,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          style_68_i,
  input  logic          addr_mux_i,
  input  logic          cs_n_i,
  input  logic [AW-1:0] a_i,
  input  logic          ale_i,
  input  logic          rd_rw_i,
  input  logic          wr_ds_i,
  input  logic [DW-1:0] data_i,
  output logic          rd_act_o,
  output logic [AW-1:0] rd_word_o,
  output logic          wcommit_o,
  output logic [AW-1:0] wword_o,
  output logic [DW-1:0] wdata_o
);
  logic          cs_s, rdrw_s, wrds_s, ale_s;
  logic [AW-1:0] a_s, alat;
  logic [DW-1:0] d_s;
  logic          wr_act, wr_act_q;
  logic [AW-1:0] word;

  // Input sampling stage; the address latch follows the bus while ALE is high.
  always_ff @(posedge clk) begin
    if (rst) begin
      cs_s   <= 1'b1;
      rdrw_s <= 1'b1;
      wrds_s <= 1'b1;
      ale_s  <= 1'b0;
      a_s    <= '0;
      d_s    <= '0;
      alat   <= '0;
    end else begin
      cs_s   <= cs_n_i;
      rdrw_s <= rd_rw_i;
      wrds_s <= wr_ds_i;
      ale_s  <= ale_i;
      a_s    <= a_i;
      d_s    <= data_i;
      if (ale_s) alat <= d_s[AW:1];
    end
  end

  always_comb begin
    word = addr_mux_i ? alat : a_s;
    if (style_68_i) begin
      rd_act_o = !cs_s && !wrds_s && rdrw_s;
      wr_act   = !cs_s && !wrds_s && !rdrw_s;
    end else begin
      rd_act_o = !cs_s && !rdrw_s && wrds_s;
      wr_act   = !cs_s && !wrds_s;
    end
  end

  // Capture while the write strobe is active, commit when it ends.
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_act_q <= 1'b0;
      wword_o  <= '0;
      wdata_o  <= '0;
    end else begin
      wr_act_q <= wr_act;
      if (wr_act) begin
        wword_o <= word;
        wdata_o <= d_s;
      end
    end
  end

  assign wcommit_o = wr_act_q && !wr_act;
  assign rd_word_o = word;
endmodule

// File: rtl/hreg_bank_sel.sv
module hreg_bank_sel #(
  parameter int NBANK     = 3,
  parameter int AW        = 5,
  parameter int DW        = 16,
  parameter int BSEL_WORD = 31,
  localparam int BW = $clog2(NBANK)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wcommit_i,
  input  logic [AW-1:0] wword_i,
  input  logic [DW-1:0] wdata_i,
  output logic [BW-1:0] bank_o
);
  always_ff @(posedge clk) begin
    if (rst)
      bank_o <= '0;
    else if (wcommit_i && wword_i == AW'(BSEL_WORD) && wdata_i < DW'(NBANK))
      bank_o <= wdata_i[BW-1:0];
  end
endmodule

// File: rtl/hreg_store.sv
module hreg_store
  import hreg_pkg::*;
#(
  parameter int NBANK       = 3,
  parameter int AW          = 5,
  parameter int DW          = 16,
  parameter int BSEL_WORD   = 31,
  parameter int COMMON_LAST = 7,
  localparam int BW    = $clog2(NBANK),
  localparam int DEPTH = NBANK << AW,
  localparam int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic [BW-1:0] bank_i,
  input  logic          wcommit_i,
  input  logic [AW-1:0] wword_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          eng_we_i,
  input  logic [BW-1:0] eng_bank_i,
  input  logic [AW-1:0] eng_word_i,
  input  logic [DW-1:0] eng_data_i,
  input  logic [AW-1:0] rd_word_i,
  output logic [DW-1:0] set_q_o,
  output logic [DW-1:0] disp_q_o
);
  logic [DW-1:0] set_mem  [DEPTH];
  logic [DW-1:0] disp_mem [DEPTH];
  loc_kind_e     wkind;
  logic          eng_ok;

  function automatic logic [IW-1:0] idx_of(input logic [BW-1:0] b, input logic [AW-1:0] w);
    if (is_common(int'(w), BSEL_WORD, COMMON_LAST)) return IW'(w);
    return IW'({b, w});
  endfunction

  assign wkind  = loc_kind(int'(bank_i), int'(wword_i), BSEL_WORD, COMMON_LAST);
  assign eng_ok = is_common(int'(eng_word_i), BSEL_WORD, COMMON_LAST) ||
                  (eng_bank_i < BW'(NBANK));

  // Host side: setting storage, one write port, one registered read port.
  always_ff @(posedge clk) begin
    if (wcommit_i && (wkind == LK_SHARED || wkind == LK_SPLIT || wkind == LK_WO))
      set_mem[idx_of(bank_i, wword_i)] <= wdata_i;
    set_q_o <= set_mem[idx_of(bank_i, rd_word_i)];
  end

  // Engine side: display storage.
  always_ff @(posedge clk) begin
    if (eng_we_i && eng_ok)
      disp_mem[idx_of(eng_bank_i, eng_word_i)] <= eng_data_i;
    disp_q_o <= disp_mem[idx_of(bank_i, rd_word_i)];
  end
endmodule

// File: rtl/hreg_port.sv
module hreg_port
  import hreg_pkg::*;
#(
  parameter int NBANK       = 3,
  parameter int AW          = 5,
  parameter int DW          = 16,
  parameter int BSEL_WORD   = 31,
  parameter int COMMON_LAST = 7,
  localparam int BW = $clog2(NBANK)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          style_68_i,
  input  logic          addr_mux_i,
  input  logic          cs_n_i,
  input  logic [AW-1:0] a_i,
  input  logic          ale_i,
  input  logic          rd_rw_i,
  input  logic          wr_ds_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  input  logic          eng_we_i,
  input  logic [BW-1:0] eng_bank_i,
  input  logic [AW-1:0] eng_word_i,
  input  logic [DW-1:0] eng_data_i
);
  logic          rd_act, wcommit;
  logic [AW-1:0] rd_word, wword;
  logic [DW-1:0] wdata, set_q, disp_q;
  logic [BW-1:0] bank, bank_rq;
  logic          act_q;
  loc_kind_e     kind_q;
  logic [DW-1:0] rd_mux;

  hreg_bus_front #(.AW(AW), .DW(DW)) u_front (
    .clk(clk), .rst(rst), .style_68_i(style_68_i), .addr_mux_i(addr_mux_i),
    .cs_n_i(cs_n_i), .a_i(a_i), .ale_i(ale_i), .rd_rw_i(rd_rw_i),
    .wr_ds_i(wr_ds_i), .data_i(data_i), .rd_act_o(rd_act), .rd_word_o(rd_word),
    .wcommit_o(wcommit), .wword_o(wword), .wdata_o(wdata)
  );

  hreg_bank_sel #(.NBANK(NBANK), .AW(AW), .DW(DW), .BSEL_WORD(BSEL_WORD)) u_bank (
    .clk(clk), .rst(rst), .wcommit_i(wcommit), .wword_i(wword),
    .wdata_i(wdata), .bank_o(bank)
  );

  hreg_store #(.NBANK(NBANK), .AW(AW), .DW(DW), .BSEL_WORD(BSEL_WORD),
               .COMMON_LAST(COMMON_LAST)) u_store (
    .clk(clk), .bank_i(bank), .wcommit_i(wcommit), .wword_i(wword),
    .wdata_i(wdata), .eng_we_i(eng_we_i), .eng_bank_i(eng_bank_i),
    .eng_word_i(eng_word_i), .eng_data_i(eng_data_i), .rd_word_i(rd_word),
    .set_q_o(set_q), .disp_q_o(disp_q)
  );

  // Stage 2: classify the location alongside the storage read.
  always_ff @(posedge clk) begin
    if (rst) begin
      act_q   <= 1'b0;
      kind_q  <= LK_RES;
      bank_rq <= '0;
    end else begin
      act_q   <= rd_act;
      kind_q  <= loc_kind(int'(bank), int'(rd_word), BSEL_WORD, COMMON_LAST);
      bank_rq <= bank;
    end
  end

  always_comb begin
    case (kind_q)
      LK_SHARED:       rd_mux = set_q;
      LK_SPLIT, LK_RO: rd_mux = disp_q;
      LK_BSEL:         rd_mux = DW'(bank_rq);
      default:         rd_mux = '0;
    endcase
  end

  // Stage 3: registered bus outputs.
  always_ff @(posedge clk) begin
    if (rst) begin
      data_oe_o <= 1'b0;
      data_o    <= '0;
    end else begin
      data_oe_o <= act_q;
      data_o    <= act_q ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/hreg_port_chk.sv
module hreg_port_chk #(
  parameter int NBANK     = 3,
  parameter int AW        = 5,
  parameter int DW        = 16,
  parameter int BSEL_WORD = 31,
  localparam int BW = $clog2(NBANK)
) (
  input logic          clk,
  input logic          rst,
  input logic [BW-1:0] bank,
  input logic          wcommit,
  input logic [AW-1:0] wword,
  input logic [DW-1:0] wdata,
  input logic          rd_act,
  input logic          data_oe_o,
  input logic [DW-1:0] data_o
);
  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (bank == '0 && !data_oe_o));

  p_quiet_bus_r2: assert property (@(posedge clk) disable iff (rst)
    !data_oe_o |-> data_o == '0);

  p_bank_range_r6: assert property (@(posedge clk) disable iff (rst)
    bank < BW'(NBANK));

  p_bank_take_r6: assert property (@(posedge clk) disable iff (rst)
    (wcommit && wword == AW'(BSEL_WORD) && wdata < DW'(NBANK))
      |=> bank == $past(wdata[BW-1:0]));

  p_bank_keep_r7: assert property (@(posedge clk) disable iff (rst)
    (wcommit && wword == AW'(BSEL_WORD) && wdata >= DW'(NBANK)) |=> $stable(bank));

  p_oe_latency_r11: assert property (@(posedge clk) disable iff (rst)
    data_oe_o == $past(rd_act, 2));
endmodule

bind hreg_port hreg_port_chk #(.NBANK(NBANK), .AW(AW), .DW(DW), .BSEL_WORD(BSEL_WORD)) u_chk (
  .clk(clk), .rst(rst), .bank(bank), .wcommit(wcommit), .wword(wword),
  .wdata(wdata), .rd_act(rd_act), .data_oe_o(data_oe_o), .data_o(data_o)
);

// File: tb/test_hreg_port.sv
module test_hreg_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        style_68 = 1'b0, addr_mux = 1'b0;
  logic        cs_n = 1'b1, ale = 1'b0, rd_rw = 1'b1, wr_ds = 1'b1;
  logic [4:0]  a = '0, a_noise = '0;
  logic [15:0] din = '0;
  logic [15:0] dout;
  logic        doe;
  logic        eng_we = 1'b0;
  logic [1:0]  eng_bank = '0;
  logic [4:0]  eng_word = '0;
  logic [15:0] eng_data = '0;
  int nchk = 0, nerr = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hreg_port i_hreg_port (
    .clk(clk), .rst(rst), .style_68_i(style_68), .addr_mux_i(addr_mux),
    .cs_n_i(cs_n), .a_i(a), .ale_i(ale), .rd_rw_i(rd_rw), .wr_ds_i(wr_ds),
    .data_i(din), .data_o(dout), .data_oe_o(doe), .eng_we_i(eng_we),
    .eng_bank_i(eng_bank), .eng_word_i(eng_word), .eng_data_i(eng_data)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic put_addr(input logic [4:0] w);
    if (addr_mux) begin
      @(negedge clk); ale = 1'b1; a = a_noise; din = {10'h0, ~w, 1'b0};
      @(negedge clk); din = {10'h0, w, 1'b0};
      @(negedge clk); ale = 1'b0; din = 16'h0;
    end else begin
      @(negedge clk); a = w;
    end
  endtask

  task automatic host_wr(input logic [4:0] w, input logic [15:0] d);
    put_addr(w);
    @(negedge clk); cs_n = 1'b0; din = d; if (style_68) rd_rw = 1'b0;
    @(negedge clk); wr_ds = 1'b0;
    repeat (3) @(negedge clk);
    wr_ds = 1'b1;
    @(negedge clk); cs_n = 1'b1; rd_rw = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic host_rd(input logic [4:0] w, output logic [15:0] d);
    put_addr(w);
    @(negedge clk); cs_n = 1'b0;
    @(negedge clk); if (style_68) wr_ds = 1'b0; else rd_rw = 1'b0;
    repeat (4) @(negedge clk);
    d = dout;
    chk("read enable", {15'h0, doe}, 16'h1);
    rd_rw = 1'b1; wr_ds = 1'b1;
    @(negedge clk); cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic eng_load(input logic [1:0] b, input logic [4:0] w, input logic [15:0] d);
    @(negedge clk); eng_we = 1'b1; eng_bank = b; eng_word = w; eng_data = d;
    @(negedge clk); eng_we = 1'b0;
  endtask

  task automatic t_reset;
    logic [15:0] r;
    chk("R1 oe after reset", {15'h0, doe}, 16'h0);
    chk("R1 data after reset", dout, 16'h0);
    host_rd(5'd31, r); chk("R1 bank after reset", r, 16'h0000);
  endtask

  task automatic t_80_style;
    logic [15:0] r;
    style_68 = 1'b0;
    host_wr(5'd0, 16'hA5A5); host_rd(5'd0, r); chk("R2 word0 readback", r, 16'hA5A5);
    host_wr(5'd2, 16'h3C3C); host_rd(5'd2, r); chk("R2 word2 readback", r, 16'h3C3C);
    // write strobe with chip deselected
    @(negedge clk); a = 5'd0; din = 16'h1111;
    @(negedge clk); wr_ds = 1'b0;
    repeat (3) @(negedge clk); wr_ds = 1'b1;
    repeat (3) @(negedge clk);
    host_rd(5'd0, r); chk("R2 deselected write ignored", r, 16'hA5A5);
    // read strobe with chip deselected
    @(negedge clk); rd_rw = 1'b0;
    repeat (5) @(negedge clk);
    chk("R2 deselected read oe", {15'h0, doe}, 16'h0);
    chk("R2 deselected read data", dout, 16'h0);
    rd_rw = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_68_style;
    logic [15:0] r;
    style_68 = 1'b1;
    host_wr(5'd0, 16'h6868); host_rd(5'd0, r); chk("R3 word0 68-style", r, 16'h6868);
    host_wr(5'd2, 16'h0F0F); host_rd(5'd2, r); chk("R3 word2 68-style", r, 16'h0F0F);
    style_68 = 1'b0;
  endtask

  task automatic t_mux;
    logic [15:0] r;
    addr_mux = 1'b1; a_noise = 5'd0;
    host_wr(5'd2, 16'h7777); host_rd(5'd2, r); chk("R4 mux word2", r, 16'h7777);
    a_noise = 5'd2;
    host_wr(5'd0, 16'h4242); host_rd(5'd0, r); chk("R4 address pins ignored", r, 16'h4242);
    addr_mux = 1'b0;
    host_rd(5'd2, r); chk("R4 mux write seen non-mux", r, 16'h7777);
    a_noise = 5'd0;
  endtask

  task automatic t_bank_sel;
    logic [15:0] r;
    host_wr(5'd31, 16'h0001); host_rd(5'd31, r); chk("R6 bank 1", r, 16'h0001);
    host_wr(5'd31, 16'h0003); host_rd(5'd31, r); chk("R7 value 3 ignored", r, 16'h0001);
    host_wr(5'd31, 16'hFFFE); host_rd(5'd31, r); chk("R7 value FFFE ignored", r, 16'h0001);
    host_wr(5'd31, 16'h0002); host_rd(5'd31, r); chk("R6 bank 2", r, 16'h0002);
    host_wr(5'd31, 16'h0005); host_rd(5'd31, r); chk("R7 value 5 ignored", r, 16'h0002);
    host_wr(5'd31, 16'h0000); host_rd(5'd31, r); chk("R6 bank 0", r, 16'h0000);
  endtask

  task automatic t_common;
    logic [15:0] r;
    host_wr(5'd31, 16'h0001); host_wr(5'd0, 16'hC001);
    host_wr(5'd31, 16'h0002); host_rd(5'd0, r); chk("R5 common word0 from bank2", r, 16'hC001);
    host_wr(5'd31, 16'h0000); host_rd(5'd0, r); chk("R5 common word0 from bank0", r, 16'hC001);
  endtask

  task automatic t_split;
    logic [15:0] r;
    eng_load(2'd2, 5'd3, 16'h1234);
    host_wr(5'd3, 16'h9999); host_rd(5'd3, r); chk("R8 common split shows display", r, 16'h1234);
    eng_load(2'd0, 5'd8, 16'h0808);
    host_wr(5'd8, 16'hEEEE); host_rd(5'd8, r); chk("R8 bank0 split shows display", r, 16'h0808);
    eng_load(2'd0, 5'd8, 16'h0809);
    host_rd(5'd8, r); chk("R8 display reload", r, 16'h0809);
  endtask

  task automatic t_reserved;
    logic [15:0] r;
    host_wr(5'd19, 16'hFFFF); host_rd(5'd19, r); chk("R9 reserved reads zero", r, 16'h0000);
    host_rd(5'd6, r); chk("R9 common reserved reads zero", r, 16'h0000);
    host_wr(5'd10, 16'hABCD); host_rd(5'd10, r); chk("R9 write-only reads zero", r, 16'h0000);
    eng_load(2'd0, 5'd1, 16'h1111);
    host_wr(5'd1, 16'h2222); host_rd(5'd1, r); chk("R9 read-only write ignored", r, 16'h1111);
  endtask

  task automatic t_banked;
    logic [15:0] r;
    host_wr(5'd31, 16'h0001); host_wr(5'd16, 16'h1016);
    host_wr(5'd31, 16'h0002); host_wr(5'd16, 16'h2016); host_wr(5'd8, 16'h2008);
    host_rd(5'd16, r); chk("R10 bank2 word16", r, 16'h2016);
    host_rd(5'd8, r);  chk("R10 bank2 word8", r, 16'h2008);
    host_wr(5'd31, 16'h0001);
    host_rd(5'd16, r); chk("R10 bank1 word16 kept", r, 16'h1016);
    host_wr(5'd31, 16'h0000);
  endtask

  task automatic t_timing;
    logic [15:0] r;
    // data changed while the write strobe is held: the last value counts
    @(negedge clk); a = 5'd2;
    @(negedge clk); cs_n = 1'b0; din = 16'h0101;
    @(negedge clk); wr_ds = 1'b0;
    @(negedge clk); din = 16'h0202;
    repeat (2) @(negedge clk); wr_ds = 1'b1;
    @(negedge clk); cs_n = 1'b1;
    repeat (3) @(negedge clk);
    host_rd(5'd2, r); chk("R11 last data in strobe", r, 16'h0202);
    // read enable latency
    @(negedge clk); a = 5'd2; cs_n = 1'b0;
    @(negedge clk); rd_rw = 1'b0;
    @(negedge clk);
    @(negedge clk); chk("R11 oe low before third edge", {15'h0, doe}, 16'h0);
    @(negedge clk); chk("R11 oe high after third edge", {15'h0, doe}, 16'h1);
    chk("R11 data with oe", dout, 16'h0202);
    rd_rw = 1'b1;
    @(negedge clk);
    @(negedge clk); chk("R11 oe held two edges after release", {15'h0, doe}, 16'h1);
    @(negedge clk); chk("R11 oe low third edge after release", {15'h0, doe}, 16'h0);
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset;
    t_80_style;
    t_68_style;
    t_mux;
    t_bank_sel;
    t_common;
    t_split;
    t_reserved;
    t_banked;
    t_timing;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end
endmodule